// File: doc/BRIEF.md
# Shared Interrupt Routing Matrix

A multi-function bridge has internal functions that raise interrupt requests, and it also receives the four PCI interrupt pins. This block steers all of these requests onto sixteen ISA IRQ lines. Each source has a 4-bit route value. Internal functions keep that value in their own interrupt-line register. The four pins take theirs from nibbles packed into three configuration bytes of function 0. More than one source may share a line, and the line stays high while any source mapped to it still requests.

The block keeps a 16-bit state vector for every ISA line, with one bit per source. Internal function f owns bit f. Pins A to D own bits 12 to 15. Each ISA line is the OR of its vector. A route value that is not allowed never reaches a line. Instead, a one-cycle error pulse reports the source and the rejected value, so that firmware mistakes can be traced.

Top module: `irq_route_matrix`

## Requirements
- R1: An ISA line is high when at least one source with a valid route to that line requests, and the sharing sources combine by OR. A change of a request level shows on `irq_out` one clock after it is sampled.
- R2: Internal function f (1 to 7, given on `fn_req[f]`) uses state bit f. Pin A, B, C, D (`pin_req[0..3]`) uses state bit 12, 13, 14, 15. `err_src` reports this bit index.
- R3: A route value of 0 disables the source. Its request drives no line and raises no error.
- R4: A route value of 2 is invalid for every source. The request drives no line.
- R5: Functions 2, 3 and 5 may route only up to 14. For them, a route of 15 is invalid and drives no line.
- R6: All other sources may route to line 15.
- R7: Pin routes come from writes with `wr_fn`=0: byte 0x55 bits [7:4] give pin A, byte 0x56 bits [3:0] give pin B, byte 0x56 bits [7:4] give pin C, and byte 0x57 bits [7:4] give pin D. Bits [3:0] of 0x55 are not a route.
- R8: The route of function f is written with `wr_fn`=f, `wr_addr`=0x3C and the value in `wr_data[3:0]`. A write to any other address leaves every route unchanged.
- R9: Reset sets all routes to 0 and clears all state, so `irq_out` is 0 and `err_pulse` is low.
- R10: When the route of an asserted source is rewritten, the old line is released and the new line is driven. Both happen in the cycle after the write takes effect.
- R11: Each change of request level (rise or fall) under an invalid route gives one `err_pulse` cycle, sampled at the same time as R1, together with `err_src` and `err_route`. If several sources fail in the same cycle, the lowest bit index is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_req | input | 7 | Request levels of internal functions 1..7 (bit index = function) |
| pin_req | input | 4 | Request levels of PCI pins A..D |
| wr_en | input | 1 | Configuration write strobe |
| wr_fn | input | 3 | Function number addressed by the write |
| wr_addr | input | 8 | Configuration byte address |
| wr_data | input | 8 | Configuration byte value |
| irq_out | output | 16 | ISA IRQ line levels |
| err_pulse | output | 1 | One-cycle invalid-route indication |
| err_src | output | 4 | State bit index of the rejected source |
| err_route | output | 4 | Rejected route value |

## Verification
A line update and an error report can fall in the same cycle. The bench provokes this by raising, at the same edge, a source with a valid route to line 15 and a limited function whose route is 15. It then expects line 15 high and an error naming function 2 in that same sampled cycle. Two errors at once are also forced, with function 3 and pin A both on route 2, and the bench judges that the lower index, 3, is reported and that the pulse is gone in the next cycle while the requests stay high.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int SRC_N    = 16;
    localparam int IRQ_N    = 16;
    localparam int RT_W     = 4;
    localparam int PIN_N    = 4;
    localparam int PIN_BASE = 12;

    typedef logic [RT_W-1:0] route_t;

    // true when a non-zero route must be rejected
    function automatic logic route_bad(input route_t rt, input logic limited);
        return (rt == route_t'(2)) || (limited && rt == route_t'(IRQ_N - 1));
    endfunction
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
    import irq_route_pkg::*;
#(
    parameter int NUM_FN    = 8,
    parameter int FN_W      = $clog2(NUM_FN),
    parameter logic [7:0] LINE_ADDR = 8'h3C,
    parameter logic [7:0] PIN_AB    = 8'h55,
    parameter logic [7:0] PIN_BC    = 8'h56,
    parameter logic [7:0] PIN_CD    = 8'h57
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [FN_W-1:0]                wr_fn,
    input  logic [7:0]                     wr_addr,
    input  logic [7:0]                     wr_data,
    output logic [SRC_N-1:0][RT_W-1:0]     src_route
);
    typedef struct packed {
        logic [NUM_FN-1:1][RT_W-1:0] fn_rt;
        logic [PIN_N-1:0][RT_W-1:0]  pin_rt;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == LINE_ADDR) begin
                for (int f = 1; f < NUM_FN; f++) begin
                    if (wr_fn == FN_W'(f)) st_d.fn_rt[f] = wr_data[RT_W-1:0];
                end
            end
            if (wr_fn == '0) begin
                if (wr_addr == PIN_AB) st_d.pin_rt[0] = wr_data[7:4];
                if (wr_addr == PIN_BC) begin
                    st_d.pin_rt[1] = wr_data[3:0];
                    st_d.pin_rt[2] = wr_data[7:4];
                end
                if (wr_addr == PIN_CD) st_d.pin_rt[3] = wr_data[7:4];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar s = 0; s < SRC_N; s++) begin : g_map
        if (s >= 1 && s < NUM_FN) begin : g_fn
            assign src_route[s] = st_q.fn_rt[s];
        end else if (s >= PIN_BASE) begin : g_pin
            assign src_route[s] = st_q.pin_rt[s-PIN_BASE];
        end else begin : g_none
            assign src_route[s] = '0;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(src_route)) else $error("route changed without write"); // R8
endmodule

// File: rtl/irq_route_err.sv
module irq_route_err
    import irq_route_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SRC_N-1:0]           flags,
    input  logic [SRC_N-1:0][RT_W-1:0] routes,
    output logic                       err_pulse,
    output logic [3:0]                 err_src,
    output logic [RT_W-1:0]            err_route
);
    typedef struct packed {
        logic            pulse;
        logic [3:0]      src;
        logic [RT_W-1:0] rt;
    } err_t;

    err_t st_d, st_q;

    always_comb begin
        st_d = '0;
        st_d.pulse = |flags;
        for (int s = SRC_N - 1; s >= 0; s--) begin
            if (flags[s]) begin
                st_d.src = 4'(s);
                st_d.rt  = routes[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_pulse = st_q.pulse;
    assign err_src   = st_q.src;
    assign err_route = st_q.rt;

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(|flags)) else $error("error without cause"); // R11
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_route_pkg::*;
#(
    parameter int NUM_FN = 8,
    parameter int FN_W   = $clog2(NUM_FN),
    parameter logic [SRC_N-1:0] LIMIT_MASK = 16'h002C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FN-1:1] fn_req,
    input  logic [PIN_N-1:0]  pin_req,
    input  logic              wr_en,
    input  logic [FN_W-1:0]   wr_fn,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [IRQ_N-1:0]  irq_out,
    output logic              err_pulse,
    output logic [3:0]        err_src,
    output logic [RT_W-1:0]   err_route
);
    typedef struct packed {
        logic [IRQ_N-1:0][SRC_N-1:0] vec;
        logic [SRC_N-1:0]            prev;
    } mat_t;

    logic [SRC_N-1:0][RT_W-1:0] src_route;
    logic [SRC_N-1:0]           req_all;
    logic [SRC_N-1:0]           bad_flag;
    mat_t st_d, st_q;

    irq_route_cfg #(.NUM_FN(NUM_FN), .FN_W(FN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fn(wr_fn),
        .wr_addr(wr_addr), .wr_data(wr_data), .src_route(src_route)
    );

    for (genvar s = 0; s < SRC_N; s++) begin : g_req
        if (s >= 1 && s < NUM_FN) begin : g_fn
            assign req_all[s] = fn_req[s];
        end else if (s >= PIN_BASE) begin : g_pin
            assign req_all[s] = pin_req[s-PIN_BASE];
        end else begin : g_none
            assign req_all[s] = 1'b0;
        end
    end

    always_comb begin
        st_d      = '0;
        bad_flag  = '0;
        st_d.prev = req_all;
        for (int s = 0; s < SRC_N; s++) begin
            if (src_route[s] != '0) begin
                if (route_bad(src_route[s], LIMIT_MASK[s])) begin
                    bad_flag[s] = req_all[s] ^ st_q.prev[s];
                end else begin
                    st_d.vec[src_route[s]][s] = req_all[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_or
        assign irq_out[i] = |st_q.vec[i];
    end

    irq_route_err u_err (
        .clk(clk), .rst_n(rst_n), .flags(bad_flag), .routes(src_route),
        .err_pulse(err_pulse), .err_src(err_src), .err_route(err_route)
    );

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|req_all) |-> irq_out == '0) else $error("line high with no request"); // R1
    AST_LINE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out[0]) else $error("disabled route reached a line"); // R3
    AST_LINE2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out[2]) else $error("route 2 reached a line"); // R4
    AST_ERR_ROUTE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_route == 4'd2 || err_route == 4'd15)) else $error("bad error route"); // R5
    AST_ERR_SRC_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_src != 4'd0 && (err_src < 4'(NUM_FN) || err_src >= 4'(PIN_BASE))))
        else $error("error names no source"); // R2
    for (genvar s = 0; s < SRC_N; s++) begin : g_col
        logic [IRQ_N-1:0] col;
        for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
            assign col[i] = st_q.vec[i][s];
        end
        AST_ONE_LINE_PER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col)) else $error("source held on two lines"); // R10
    end
endmodule

// File: tb/sim_irq_route_matrix.sv
module sim_irq_route_matrix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:1]  fn_req = '0;
    logic [3:0]  pin_req = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_fn = '0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] irq_out;
    logic        err_pulse;
    logic [3:0]  err_src;
    logic [3:0]  err_route;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_route_matrix u0 (
        .clk(clk), .rst_n(rst_n), .fn_req(fn_req), .pin_req(pin_req),
        .wr_en(wr_en), .wr_fn(wr_fn), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_out(irq_out), .err_pulse(err_pulse), .err_src(err_src), .err_route(err_route)
    );

    // {fn mask[7:0] (bit = function), pins[3:0], irq[15:0], err, src[3:0], route[3:0]}
    localparam logic [36:0] TBL [0:8] = '{
        {8'h02, 4'b0000, 16'h0020, 1'b0, 4'd0, 4'd0},
        {8'h06, 4'b0000, 16'h0220, 1'b0, 4'd0, 4'd0},
        {8'h0C, 4'b0000, 16'h0200, 1'b0, 4'd0, 4'd0},
        {8'h08, 4'b0010, 16'h0200, 1'b0, 4'd0, 4'd0},
        {8'h10, 4'b0010, 16'h8200, 1'b0, 4'd0, 4'd0},
        {8'h60, 4'b1101, 16'hC808, 1'b0, 4'd0, 4'd0},
        {8'h80, 4'b0000, 16'h0000, 1'b1, 4'd7, 4'd2},
        {8'h80, 4'b1000, 16'h0008, 1'b0, 4'd0, 4'd0},
        {8'h00, 4'b0000, 16'h0000, 1'b1, 4'd7, 4'd2}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_fn = f; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset irq", 32'(irq_out), 32'h0);
        chk("R9 reset err", 32'(err_pulse), 32'h0);
        rst_n = 1'b1;
        // routes: f1->5 f2->9 f3->9 f4->15 f5->14 f6->0 f7->2, A->11 B->9 C->15 D->3
        wr(3'd1, 8'h3C, 8'h05); wr(3'd2, 8'h3C, 8'h09); wr(3'd3, 8'h3C, 8'hA9);
        wr(3'd4, 8'h3C, 8'h0F); wr(3'd5, 8'h3C, 8'h0E); wr(3'd6, 8'h3C, 8'h00);
        wr(3'd7, 8'h3C, 8'h02);
        wr(3'd0, 8'h55, 8'hB0); wr(3'd0, 8'h56, 8'hF9); wr(3'd0, 8'h57, 8'h30);
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            fn_req  = TBL[k][36:30];
            pin_req = TBL[k][28:25];
            @(negedge clk);
            chk("R1 R2 R6 R7 table irq", 32'(irq_out), 32'(TBL[k][24:9]));
            chk("R3 R4 R11 table err", 32'(err_pulse), 32'(TBL[k][8]));
            if (TBL[k][8]) chk("R2 R11 table src/route", 32'({err_src, err_route}), 32'(TBL[k][7:0]));
        end
        // R5 and R6 in one cycle
        wr(3'd1, 8'h3C, 8'h0F); wr(3'd2, 8'h3C, 8'h0F);
        @(negedge clk); fn_req = 7'b0000011;
        @(negedge clk);
        chk("R6 fn1 on line 15", 32'(irq_out), 32'h8000);
        chk("R5 fn2 route 15 error", 32'({err_pulse, err_src, err_route}), 32'({1'b1, 4'd2, 4'd15}));
        fn_req = '0;
        @(negedge clk);
        chk("R11 falling edge error", 32'({err_pulse, err_src, err_route}), 32'({1'b1, 4'd2, 4'd15}));
        chk("R1 lines released", 32'(irq_out), 32'h0);
        // R11 priority
        wr(3'd3, 8'h3C, 8'h02); wr(3'd0, 8'h55, 8'h20);
        @(negedge clk); fn_req = 7'b0000100; pin_req = 4'b0001;
        @(negedge clk);
        chk("R11 lowest index wins", 32'({err_pulse, err_src, err_route}), 32'({1'b1, 4'd3, 4'd2}));
        chk("R4 route 2 no line", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R11 single pulse", 32'(err_pulse), 32'h0);
        fn_req = '0; pin_req = '0;
        @(negedge clk);
        // R10 reroute
        wr(3'd1, 8'h3C, 8'h05);
        fn_req = 7'b0000001;
        @(negedge clk);
        chk("R1 fn1 line 5", 32'(irq_out), 32'h0020);
        wr(3'd1, 8'h3C, 8'h07);
        @(negedge clk);
        chk("R10 moved to line 7", 32'(irq_out), 32'h0080);
        wr(3'd1, 8'h3D, 8'h04);
        @(negedge clk);
        chk("R8 other address ignored", 32'(irq_out), 32'h0080);
        wr(3'd1, 8'h3C, 8'h00);
        @(negedge clk);
        chk("R3 disabled releases line", 32'({irq_out, err_pulse}), 32'h0);
        fn_req = '0;
        @(negedge clk);
        chk("R3 no error when disabled", 32'(err_pulse), 32'h0);
        // R7 low nibble of 0x55 is not pin A
        wr(3'd0, 8'h55, 8'h0B);
        pin_req = 4'b0001;
        @(negedge clk);
        chk("R7 0x55 low nibble ignored", 32'({irq_out, err_pulse}), 32'h0);
        pin_req = '0;
        // R9 reset clears routes
        wr(3'd4, 8'h3C, 8'h06);
        fn_req = 7'b0001000;
        @(negedge clk);
        chk("R1 fn4 line 6", 32'(irq_out), 32'h0040);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset drops lines", 32'(irq_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 routes cleared", 32'({irq_out, err_pulse}), 32'h0);
        summary();
    end
endmodule